// File: doc/BRIEF.md
# Packet DRAM Power-State Controller

This block keeps track of which of six power states a packet-based DRAM device is in, and it drives the power enables for each of the device's internal sub-blocks. The host issues single-cycle commands to sleep, to nap, to wake and to relax. Packet strobes and read/write burst indications move the controller between standby, attention and the two data-active attention states. Every enable, the one-hot state vector and the refresh-mode select are decoded from a single registered state, so all of them change together.

Leaving a sleep state is not instant. A wake from nap runs a short programmable exit countdown. A wake from power-down runs a longer one, because clock synchronisation must be rebuilt. While either countdown runs, `busy` is high and no packet is accepted. Nap keeps its clock alignment only for a limited time. When a programmable residency limit is reached, the controller starts a nap exit by itself and returns to standby, and the host may then put it back into nap.

Row and column packets enter through a valid/ready pair. A packet counts only in a cycle where its strobe and the matching ready are both high. A strobe given while ready is low is dropped, not held, so the sender must keep it up or present it again. Ready is never withdrawn in the middle of a cycle, because it comes only from registered state.

Top module: `pwr_state_ctrl`

## Requirements
- R1: During and right after synchronous reset, the state is power-down, every enable is low, `busy` is low, and both readies are low.
- R2: `state_oh` is one-hot with the bit order 0 power-down, 1 nap, 2 standby, 3 attention, 4 attention-read, 5 attention-write.
- R3: The enables per state are as follows. Power-down: none. Nap: `en_clk_nap` only. Standby: `en_clk` and `en_row`. Attention: standby's set plus `en_col`. Attention-read: attention's set plus `en_dtx` and `en_core`. Attention-write: attention's set plus `en_drx` and `en_core`.
- R4: `ref_self` is 1 in power-down, equals `cfg_nap_selfref` in nap, and is 0 in every other state.
- R5: In standby, an accepted row packet moves the state to attention on the next cycle. In attention, `cmd_relax` moves it to standby. `cmd_relax` has no effect in other states.
- R6: In attention, a high `rd_burst` moves the state to attention-read. Otherwise a high `wr_burst` moves it to attention-write. Each of those states returns to attention in the cycle after its own burst indication goes low.
- R7: `cmd_pdn` and `cmd_nap` act only in standby or attention, and only while both burst indications are low. If both are given, power-down wins. In all other cases they have no effect.
- R8: A `cmd_wake` in nap raises `busy` for max(`cfg_nap_exit`,1) cycles. The state is standby in the cycle after `busy` falls.
- R9: A `cmd_wake` in power-down raises `busy` for max(`cfg_pdn_exit`,1) cycles, then the state goes to standby in the same way.
- R10: After max(`cfg_nap_limit`,1) consecutive nap cycles with `busy` low, a nap exit as in R8 starts without any command.
- R11: `busy` is high only in nap or power-down. While it is high, every command and packet strobe is ignored.
- R12: `row_rdy` is high exactly when the row receiver is enabled and `busy` is low. `col_rdy` follows the same rule with the column receiver.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_pdn | input | 1 | Request power-down |
| cmd_nap | input | 1 | Request nap |
| cmd_wake | input | 1 | Leave nap or power-down |
| cmd_relax | input | 1 | Drop from attention to standby |
| row_pkt | input | 1 | Row packet valid |
| col_pkt | input | 1 | Column packet valid (no state effect) |
| rd_burst | input | 1 | Read data burst in progress |
| wr_burst | input | 1 | Write data burst in progress |
| cfg_nap_selfref | input | 1 | 1: nap retains the core with self-refresh; 0: with external auto-refresh |
| cfg_nap_exit | input | EXIT_W | Nap exit length in cycles |
| cfg_pdn_exit | input | EXIT_W | Power-down exit length in cycles |
| cfg_nap_limit | input | LIM_W | Maximum idle nap residency in cycles |
| state_oh | output | 6 | One-hot state |
| en_clk | output | 1 | Clock-sync block fully on |
| en_clk_nap | output | 1 | Clock-sync block in nap mode |
| en_row | output | 1 | Row packet receiver enable |
| en_col | output | 1 | Column packet receiver enable |
| en_drx | output | 1 | Write data receiver enable |
| en_dtx | output | 1 | Read data transmitter enable |
| en_core | output | 1 | Core power enable |
| ref_self | output | 1 | Refresh mode: 1 self-refresh, 0 external auto-refresh |
| busy | output | 1 | Exit countdown running |
| row_rdy | output | 1 | Row packet ready |
| col_rdy | output | 1 | Column packet ready |

## Verification
A command, strobe or burst level sampled at clock edge k shows up in the registered state, and therefore in every enable and ready, in the cycle that starts at edge k. No result is due any later, except the exit countdown: there `busy` stays high for the programmed number of cycles and standby appears in the cycle after it falls. The nap-limit exit also comes later, after the programmed number of idle nap cycles. The bench updates a behavioural model at each rising edge from the same inputs the design sees. It compares every output at the following falling edge, so each result is checked in the exact cycle it is due, and inputs are changed only after that comparison.

// File: rtl/pwr_state_pkg.sv
package pwr_state_pkg;
  localparam int NUM_STATES = 6;

  typedef enum logic [2:0] {
    PS_DOWN = 3'd0,
    PS_NAP  = 3'd1,
    PS_STBY = 3'd2,
    PS_ATTN = 3'd3,
    PS_ATTR = 3'd4,
    PS_ATTW = 3'd5
  } pstate_e;

  typedef struct packed {
    logic clk_full;
    logic clk_nap;
    logic row;
    logic col;
    logic drx;
    logic dtx;
    logic core;
  } blk_en_t;
endpackage

// File: rtl/pwr_exit_timer.sv
module pwr_exit_timer #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         busy,
  output logic         done
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (load && !busy) begin
      busy <= 1'b1;
      cnt  <= (load_val == '0) ? ONE : load_val;
    end else if (busy) begin
      if (cnt == ONE) begin
        busy <= 1'b0;
        cnt  <= '0;
      end else begin
        cnt <= cnt - ONE;
      end
    end
  end

  assign done = busy && (cnt == ONE);

  // R8 / R9: a running countdown never sits at zero
  a_r8_count_live: assert property (@(posedge clk) disable iff (rst)
    busy |-> (cnt != '0));
endmodule

// File: rtl/pwr_nap_guard.sv
module pwr_nap_guard #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         active,
  input  logic [W-1:0] limit,
  output logic         expire
);
  logic [W-1:0] cnt;
  logic [W-1:0] lim_eff;

  assign lim_eff = (limit == '0) ? W'(1) : limit;
  assign expire  = active && (({1'b0, cnt} + (W+1)'(1)) >= {1'b0, lim_eff});

  always_ff @(posedge clk) begin
    if (rst || !active) cnt <= '0;
    else if (!expire)   cnt <= cnt + W'(1);
  end

  // R10: residency never passes the programmed bound
  a_r10_within_limit: assert property (@(posedge clk) disable iff (rst)
    active |-> (cnt < lim_eff));
endmodule

// File: rtl/pwr_enable_decode.sv
module pwr_enable_decode
  import pwr_state_pkg::*;
(
  input  pstate_e                 st,
  input  logic                    cfg_nap_selfref,
  output logic [NUM_STATES-1:0]   st_oh,
  output blk_en_t                 en,
  output logic                    ref_self
);
  for (genvar i = 0; i < NUM_STATES; i++) begin : g_oh
    assign st_oh[i] = (st == pstate_e'(i));
  end

  always_comb begin
    en       = '0;
    ref_self = 1'b0;
    unique case (st)
      PS_DOWN: ref_self = 1'b1;
      PS_NAP: begin
        en.clk_nap = 1'b1;
        ref_self   = cfg_nap_selfref;
      end
      PS_STBY: begin
        en.clk_full = 1'b1;
        en.row      = 1'b1;
      end
      PS_ATTN: begin
        en.clk_full = 1'b1;
        en.row      = 1'b1;
        en.col      = 1'b1;
      end
      PS_ATTR: begin
        en.clk_full = 1'b1;
        en.row      = 1'b1;
        en.col      = 1'b1;
        en.dtx      = 1'b1;
        en.core     = 1'b1;
      end
      PS_ATTW: begin
        en.clk_full = 1'b1;
        en.row      = 1'b1;
        en.col      = 1'b1;
        en.drx      = 1'b1;
        en.core     = 1'b1;
      end
      default: ref_self = 1'b1;
    endcase
  end
endmodule

// File: rtl/pwr_state_ctrl.sv
module pwr_state_ctrl
  import pwr_state_pkg::*;
#(
  parameter int EXIT_W = 12,
  parameter int LIM_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_pdn,
  input  logic              cmd_nap,
  input  logic              cmd_wake,
  input  logic              cmd_relax,
  input  logic              row_pkt,
  input  logic              col_pkt,
  input  logic              rd_burst,
  input  logic              wr_burst,
  input  logic              cfg_nap_selfref,
  input  logic [EXIT_W-1:0] cfg_nap_exit,
  input  logic [EXIT_W-1:0] cfg_pdn_exit,
  input  logic [LIM_W-1:0]  cfg_nap_limit,
  output logic [5:0]        state_oh,
  output logic              en_clk,
  output logic              en_clk_nap,
  output logic              en_row,
  output logic              en_col,
  output logic              en_drx,
  output logic              en_dtx,
  output logic              en_core,
  output logic              ref_self,
  output logic              busy,
  output logic              row_rdy,
  output logic              col_rdy
);
  pstate_e           st, st_nxt;
  blk_en_t           en;
  logic              exit_load, exit_done, nap_active, nap_expire;
  logic              burst, sleep_ok;
  logic [EXIT_W-1:0] exit_val;

  assign burst      = rd_burst | wr_burst;
  assign sleep_ok   = !burst;
  assign nap_active = (st == PS_NAP) && !busy;
  assign exit_load  = !busy && (((st == PS_DOWN) && cmd_wake) ||
                                ((st == PS_NAP) && (cmd_wake || nap_expire)));
  assign exit_val   = (st == PS_DOWN) ? cfg_pdn_exit : cfg_nap_exit;

  pwr_exit_timer #(.W(EXIT_W)) u_exit (
    .clk(clk), .rst(rst), .load(exit_load), .load_val(exit_val),
    .busy(busy), .done(exit_done)
  );

  pwr_nap_guard #(.W(LIM_W)) u_guard (
    .clk(clk), .rst(rst), .active(nap_active), .limit(cfg_nap_limit),
    .expire(nap_expire)
  );

  pwr_enable_decode u_dec (
    .st(st), .cfg_nap_selfref(cfg_nap_selfref),
    .st_oh(state_oh), .en(en), .ref_self(ref_self)
  );

  always_comb begin
    st_nxt = st;
    if (busy) begin
      if (exit_done) st_nxt = PS_STBY;
    end else begin
      unique case (st)
        PS_STBY: begin
          if (sleep_ok && cmd_pdn)      st_nxt = PS_DOWN;
          else if (sleep_ok && cmd_nap) st_nxt = PS_NAP;
          else if (row_pkt && row_rdy)  st_nxt = PS_ATTN;
        end
        PS_ATTN: begin
          if (rd_burst)      st_nxt = PS_ATTR;
          else if (wr_burst) st_nxt = PS_ATTW;
          else if (cmd_pdn)  st_nxt = PS_DOWN;
          else if (cmd_nap)  st_nxt = PS_NAP;
          else if (cmd_relax) st_nxt = PS_STBY;
        end
        PS_ATTR: if (!rd_burst) st_nxt = PS_ATTN;
        PS_ATTW: if (!wr_burst) st_nxt = PS_ATTN;
        default: st_nxt = st;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) st <= PS_DOWN;
    else     st <= st_nxt;
  end

  assign en_clk     = en.clk_full;
  assign en_clk_nap = en.clk_nap;
  assign en_row     = en.row;
  assign en_col     = en.col;
  assign en_drx     = en.drx;
  assign en_dtx     = en.dtx;
  assign en_core    = en.core;
  assign row_rdy    = en.row & ~busy;
  assign col_rdy    = en.col & ~busy;

  a_r2_onehot: assert property (@(posedge clk) disable iff (rst)
    $countones(state_oh) == 1);

  a_r11_busy_only_asleep: assert property (@(posedge clk) disable iff (rst)
    busy |-> (state_oh[0] || state_oh[1]));

  a_r8_exit_lands_stby: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> state_oh[2]);

  a_r7_burst_blocks_sleep: assert property (@(posedge clk) disable iff (rst)
    (burst && (state_oh[2] || state_oh[3])) |=> !(state_oh[0] || state_oh[1]));

  a_r6_read_holds: assert property (@(posedge clk) disable iff (rst)
    (state_oh[4] && rd_burst) |=> state_oh[4]);

  a_r3_col_needs_row: assert property (@(posedge clk) disable iff (rst)
    en_col |-> (en_row && en_clk));

  a_r12_no_ready_asleep: assert property (@(posedge clk) disable iff (rst)
    (state_oh[0] || state_oh[1]) |-> !(row_rdy || col_rdy));
endmodule

// File: tb/pwr_state_ctrl_test.sv
`timescale 1ns/1ps
module pwr_state_ctrl_test;
  localparam int EXIT_W = 12;
  localparam int LIM_W  = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_pdn = 0, cmd_nap = 0, cmd_wake = 0, cmd_relax = 0;
  logic row_pkt = 0, col_pkt = 0, rd_burst = 0, wr_burst = 0;
  logic cfg_nap_selfref = 0;
  logic [EXIT_W-1:0] cfg_nap_exit = 4, cfg_pdn_exit = 20;
  logic [LIM_W-1:0]  cfg_nap_limit = 1000;
  logic [5:0] state_oh;
  logic en_clk, en_clk_nap, en_row, en_col, en_drx, en_dtx, en_core;
  logic ref_self, busy, row_rdy, col_rdy;

  always #2 clk = ~clk;

  pwr_state_ctrl #(.EXIT_W(EXIT_W), .LIM_W(LIM_W)) uut (
    .clk(clk), .rst(rst), .cmd_pdn(cmd_pdn), .cmd_nap(cmd_nap),
    .cmd_wake(cmd_wake), .cmd_relax(cmd_relax), .row_pkt(row_pkt),
    .col_pkt(col_pkt), .rd_burst(rd_burst), .wr_burst(wr_burst),
    .cfg_nap_selfref(cfg_nap_selfref), .cfg_nap_exit(cfg_nap_exit),
    .cfg_pdn_exit(cfg_pdn_exit), .cfg_nap_limit(cfg_nap_limit),
    .state_oh(state_oh), .en_clk(en_clk), .en_clk_nap(en_clk_nap),
    .en_row(en_row), .en_col(en_col), .en_drx(en_drx), .en_dtx(en_dtx),
    .en_core(en_core), .ref_self(ref_self), .busy(busy),
    .row_rdy(row_rdy), .col_rdy(col_rdy)
  );

  // model: 0 down, 1 nap, 2 standby, 3 attention, 4 att-read, 5 att-write
  int m_st = 0;
  int m_left = 0;
  int m_nap = 0;
  int checks = 0;
  int errors = 0;
  bit finished = 0;
  string cur_req = "R1";

  function automatic int at_least_one(int v);
    return (v < 1) ? 1 : v;
  endfunction

  task automatic model_step();
    if (rst) begin
      m_st = 0; m_left = 0; m_nap = 0;
    end else if (m_left > 0) begin
      if (m_left == 1) begin m_st = 2; m_left = 0; end
      else m_left--;
    end else begin
      case (m_st)
        0: if (cmd_wake) m_left = at_least_one(int'(cfg_pdn_exit));
        1: if (cmd_wake || (m_nap + 1 >= at_least_one(int'(cfg_nap_limit)))) begin
             m_left = at_least_one(int'(cfg_nap_exit)); m_nap = 0;
           end else m_nap++;
        2: if (!rd_burst && !wr_burst && cmd_pdn) m_st = 0;
           else if (!rd_burst && !wr_burst && cmd_nap) begin m_st = 1; m_nap = 0; end
           else if (row_pkt) m_st = 3;
        3: if (rd_burst) m_st = 4;
           else if (wr_burst) m_st = 5;
           else if (cmd_pdn) m_st = 0;
           else if (cmd_nap) begin m_st = 1; m_nap = 0; end
           else if (cmd_relax) m_st = 2;
        4: if (!rd_burst) m_st = 3;
        5: if (!wr_burst) m_st = 3;
        default: m_st = 0;
      endcase
    end
  endtask

  task automatic check_bits(string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    logic [6:0] e_en;   // clk, clk_nap, row, col, drx, dtx, core
    logic e_ref;
    logic e_busy;
    case (m_st)
      0: e_en = 7'b0000000;
      1: e_en = 7'b0100000;
      2: e_en = 7'b1010000;
      3: e_en = 7'b1011000;
      4: e_en = 7'b1011011;
      default: e_en = 7'b1011101;
    endcase
    e_ref  = (m_st == 0) ? 1'b1 : (m_st == 1) ? cfg_nap_selfref : 1'b0;
    e_busy = (m_left > 0);
    check_bits("state_oh", 16'(state_oh), 16'(6'b1 << m_st));
    check_bits("enables", 16'({en_clk, en_clk_nap, en_row, en_col, en_drx, en_dtx, en_core}), 16'(e_en));
    check_bits("ref_self", 16'(ref_self), 16'(e_ref));
    check_bits("busy", 16'(busy), 16'(e_busy));
    check_bits("ready", 16'({row_rdy, col_rdy}),
               16'({e_en[4] & ~e_busy, e_en[3] & ~e_busy}));
  endtask

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      model_step();
      @(negedge clk);
      compare();
    end
  endtask

  task automatic pulse_wake();
    cmd_wake = 1; tick(); cmd_wake = 0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    // R1: reset state
    cur_req = "R1";
    tick(3);
    rst = 0;
    tick(2);
    check_bits("R1 reset outputs", 16'({state_oh, en_clk, en_row, busy, row_rdy}), 16'({6'b000001, 4'b0}));

    // R9: long exit from power-down
    cur_req = "R9";
    cfg_pdn_exit = 20;
    pulse_wake();
    tick(25);

    // R5: row packet into attention, relax back
    cur_req = "R5";
    cmd_relax = 1; tick(); cmd_relax = 0;         // ignored in standby
    row_pkt = 1; tick(); row_pkt = 0;
    tick(2);
    cmd_relax = 1; tick(); cmd_relax = 0;
    row_pkt = 1; col_pkt = 1; tick(); row_pkt = 0; col_pkt = 0;

    // R6: bursts
    cur_req = "R6";
    rd_burst = 1; tick(5); rd_burst = 0; tick(2);
    wr_burst = 1; tick(4); wr_burst = 0; tick(2);
    rd_burst = 1; wr_burst = 1; tick(3); rd_burst = 0; tick(2); wr_burst = 0; tick(2);

    // R7: sleep requests blocked by bursts and outside standby/attention
    cur_req = "R7";
    rd_burst = 1; cmd_pdn = 1; tick(); cmd_pdn = 0; tick(2); rd_burst = 0; tick(2);
    cmd_relax = 1; tick(); cmd_relax = 0;
    wr_burst = 1; cmd_nap = 1; tick(); cmd_nap = 0; wr_burst = 0; tick(2);
    cmd_pdn = 1; cmd_nap = 1; tick(); cmd_pdn = 0; cmd_nap = 0; tick(2);
    cmd_nap = 1; tick(); cmd_nap = 0;              // ignored in power-down
    cfg_pdn_exit = 0;
    pulse_wake(); tick(3);

    // R4: refresh select in nap
    cur_req = "R4";
    cfg_nap_selfref = 1;
    cmd_nap = 1; tick(); cmd_nap = 0; tick(3);
    cfg_nap_selfref = 0; tick(2);

    // R8: nap exit
    cur_req = "R8";
    cfg_nap_exit = 3;
    pulse_wake(); tick(5);
    row_pkt = 1; tick(); row_pkt = 0;
    cmd_nap = 1; tick(); cmd_nap = 0;
    cfg_nap_exit = 0;
    pulse_wake(); tick(3);

    // R11: inputs ignored during exit countdown
    cur_req = "R11";
    cfg_nap_exit = 8;
    cmd_nap = 1; tick(); cmd_nap = 0;
    pulse_wake();
    cmd_pdn = 1; row_pkt = 1; col_pkt = 1; cmd_wake = 1; rd_burst = 1; tick(3);
    cmd_pdn = 0; row_pkt = 0; col_pkt = 0; cmd_wake = 0; rd_burst = 0; tick(8);

    // R10: nap residency limit forces exit
    cur_req = "R10";
    cfg_nap_limit = 6; cfg_nap_exit = 2;
    cmd_nap = 1; tick(); cmd_nap = 0;
    tick(20);
    cfg_nap_limit = 0;
    cmd_nap = 1; tick(); cmd_nap = 0;
    tick(8);

    // R3 / R12: walk through all states once more
    cur_req = "R3";
    row_pkt = 1; tick(); row_pkt = 0;
    rd_burst = 1; tick(2); rd_burst = 0; tick();
    wr_burst = 1; tick(2); wr_burst = 0; tick();
    cur_req = "R12";
    cmd_pdn = 1; tick(); cmd_pdn = 0; tick(2);

    finish_run();
  end
endmodule